// File: doc/BRIEF.md
# Sequence-Decoded Multiply/Divide Coprocessor

This block is an arithmetic helper for an 8-bit processor. The processor sees it as eight byte-wide locations. Six of them are operand bytes, named OP0 to OP5. The seventh is a control byte that holds the shift direction and the shift count. The eighth is a read-only status byte. There is no opcode. The coprocessor works out what to do from the order in which the processor writes the operand bytes. It recognises four operations: a 32-by-16 divide, a 16-by-16 divide, a 16-by-16 multiply, and a 32-bit shift or normalize.

The write that completes a recognised sequence launches the calculation. The calculation then runs for several clock cycles while the processor carries on with other work. The processor can poll `busy` or the done flag in the status byte. When the calculation ends, it reads the results back from the same operand bytes. If the processor touches an operand byte while a calculation is running, the error flag latches.

Top module: `muldiv_copro`

## Requirements
- R1: A sequence is only recognised if it begins with a write to OP0 (address 0), and any later write to OP0 starts a new sequence. A write that breaks the expected order cancels the sequence, and no calculation starts.
- R2: Writing OP0, OP1, OP2, OP3 (dividend, least significant byte first), then OP4 and OP5 (divisor, low byte first) starts a 32/16 divide. `busy` is high for 32 cycles. The quotient is returned in OP0..OP3 and the remainder in OP4..OP5.
- R3: Writing OP0, OP1 (dividend), then OP4 and OP5 (divisor) starts a 16/16 divide. `busy` is high for 16 cycles. The quotient is returned in OP0..OP1, OP2..OP3 read zero, and the remainder is returned in OP4..OP5.
- R4: Writing OP0, OP4, OP1, OP5 starts a multiply of {OP1,OP0} by {OP5,OP4}. `busy` is high for 16 cycles, and the 32-bit product is returned in OP0..OP3.
- R5: Writing OP0..OP3 and then the control byte (address 6) with a nonzero count in bits 4:0 starts a logical shift of {OP3..OP0} by exactly that count. Bit 7 of the control byte selects the direction: 0 shifts left and 1 shifts right. `busy` is high for count cycles.
- R6: A control byte count of zero selects normalize. The value is shifted left until bit 31 is 1, or until 31 shifts have been made. The number of shifts performed is then readable in control byte bits 4:0.
- R7: Status bit 1 (overflow) is set in three cases. The first is a divide whose divisor is zero; such a divide runs no calculation and leaves the operands as written. The second is a multiply whose product is greater than 0000FFFFh. The third is a normalize that starts with bit 31 already set. The overflow flag is cleared by a write to OP0.
- R8: Status bit 0 (done) is set the cycle after a calculation ends. It is cleared when the next calculation starts, and it is never high while `busy` is high.
- R9: Status bit 2 (error) is set by any read or write of OP0..OP5 while `busy` is high, and such writes are ignored. The flag is cleared only by a read of OP0..OP5 while done is high.
- R10: A read returns the addressed byte on `rdata` one cycle after `rd_en`. The reset value of every flag and of `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| rd_en | input | 1 | Read strobe for the byte at `addr` |
| addr | input | 3 | 0..5 operand bytes, 6 control, 7 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High while a calculation runs |

## Verification
The bench uses the default configuration: 16-bit half words, a 32-bit accumulator and a 5-bit shift counter. With these values the full 32-step divide, every shift count from 1 to 31, and the saturated 31-shift normalize of a zero value can all be reached in a few hundred cycles per operation. This lets the random trials cover both ends of the count range and the overflow threshold of the multiply.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int FULL_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(FULL_W);
  localparam int STEP_W = CNT_W + 1;

  localparam logic [2:0] A_OP0  = 3'd0;
  localparam logic [2:0] A_OP1  = 3'd1;
  localparam logic [2:0] A_OP2  = 3'd2;
  localparam logic [2:0] A_OP3  = 3'd3;
  localparam logic [2:0] A_OP4  = 3'd4;
  localparam logic [2:0] A_OP5  = 3'd5;
  localparam logic [2:0] A_CTRL = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;

  typedef enum logic [2:0] {
    OP_NONE, OP_DIV32, OP_DIV16, OP_MUL, OP_SHIFT
  } mdu_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_L0, SQ_D1, SQ_D2, SQ_D3, SQ_D4, SQ_S2, SQ_M1, SQ_M2
  } seq_st_e;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr,
  input  logic [2:0] addr,
  output logic    start,
  output mdu_op_e op
);
  seq_st_e st, st_nx;

  always_comb begin
    st_nx = st;
    start = 1'b0;
    op    = OP_NONE;
    if (wr) begin
      if (addr == A_OP0) begin
        st_nx = SQ_L0;
      end else begin
        st_nx = SQ_IDLE;
        case (st)
          SQ_L0: if (addr == A_OP1) st_nx = SQ_D1; else if (addr == A_OP4) st_nx = SQ_M1;
          SQ_D1: if (addr == A_OP2) st_nx = SQ_D2; else if (addr == A_OP4) st_nx = SQ_S2;
          SQ_D2: if (addr == A_OP3) st_nx = SQ_D3;
          SQ_D3: begin
            if (addr == A_OP4) st_nx = SQ_D4;
            else if (addr == A_CTRL) begin start = 1'b1; op = OP_SHIFT; end
          end
          SQ_D4: if (addr == A_OP5) begin start = 1'b1; op = OP_DIV32; end
          SQ_S2: if (addr == A_OP5) begin start = 1'b1; op = OP_DIV16; end
          SQ_M1: if (addr == A_OP1) st_nx = SQ_M2;
          SQ_M2: if (addr == A_OP5) begin start = 1'b1; op = OP_MUL; end
          default: st_nx = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= st_nx;
  end

  // R1: a launch always comes from a sequence that was opened by OP0
  p_start_after_op0_r1: assert property (@(posedge clk) disable iff (rst)
    start |-> (st != SQ_IDLE));
endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  mdu_op_e    op,
  input  logic       wr,
  input  logic [2:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [2:0] raddr,
  output logic [BYTE_W-1:0] rbyte,
  output logic       busy,
  output logic       fin,
  output logic       ovf_set
);
  logic [FULL_W-1:0] acc;
  logic [HALF_W-1:0] hi, dvs;
  logic              dir, norm;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] stepc;
  mdu_op_e           run_op;

  // values as seen including the launching write
  logic [HALF_W-1:0] hi_v;
  logic [CNT_W-1:0]  cnt_v;
  logic              dir_v;
  assign hi_v  = (wr && waddr == A_OP5) ? {wdata, hi[BYTE_W-1:0]} : hi;
  assign cnt_v = (wr && waddr == A_CTRL) ? wdata[CNT_W-1:0] : cnt;
  assign dir_v = (wr && waddr == A_CTRL) ? wdata[BYTE_W-1] : dir;

  // restoring divide step
  logic [HALF_W:0]   trial;
  logic              q_bit;
  logic [HALF_W-1:0] rem_nx;
  assign trial  = {hi, acc[FULL_W-1]};
  assign q_bit  = trial >= {1'b0, dvs};
  assign rem_nx = q_bit ? (trial[HALF_W-1:0] - dvs) : trial[HALF_W-1:0];

  // shift-add multiply step
  logic [HALF_W:0] sum;
  assign sum = {1'b0, acc[FULL_W-1:HALF_W]} + (acc[0] ? {1'b0, dvs} : '0);

  logic last;
  assign last = (stepc == STEP_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; hi <= '0; dvs <= '0; dir <= 1'b0; norm <= 1'b0; cnt <= '0;
      stepc <= '0; run_op <= OP_NONE; busy <= 1'b0; fin <= 1'b0; ovf_set <= 1'b0;
    end else begin
      fin     <= 1'b0;
      ovf_set <= 1'b0;
      if (start) begin
        run_op <= op;
        case (op)
          OP_DIV32, OP_DIV16: begin
            if (hi_v == '0) begin
              hi <= hi_v; fin <= 1'b1; ovf_set <= 1'b1;
            end else begin
              busy  <= 1'b1;
              dvs   <= hi_v;
              hi    <= '0;
              stepc <= (op == OP_DIV32) ? STEP_W'(FULL_W) : STEP_W'(HALF_W);
              if (op == OP_DIV16) acc <= {acc[HALF_W-1:0], {HALF_W{1'b0}}};
            end
          end
          OP_MUL: begin
            busy  <= 1'b1;
            hi    <= hi_v;
            dvs   <= acc[HALF_W-1:0];
            acc   <= {{HALF_W{1'b0}}, hi_v};
            stepc <= STEP_W'(HALF_W);
          end
          default: begin
            busy  <= 1'b1;
            dir   <= dir_v;
            cnt   <= cnt_v;
            norm  <= (cnt_v == '0);
            stepc <= STEP_W'(cnt_v);
          end
        endcase
      end else if (busy) begin
        case (run_op)
          OP_DIV32, OP_DIV16: begin
            hi    <= rem_nx;
            acc   <= {acc[FULL_W-2:0], q_bit};
            stepc <= stepc - 1'b1;
            if (last) begin busy <= 1'b0; fin <= 1'b1; end
          end
          OP_MUL: begin
            acc   <= {sum, acc[HALF_W-1:1]};
            stepc <= stepc - 1'b1;
            if (last) begin
              busy <= 1'b0; fin <= 1'b1; ovf_set <= |sum[HALF_W:1];
            end
          end
          default: begin
            if (norm) begin
              if (acc[FULL_W-1] || cnt == '1) begin
                busy <= 1'b0; fin <= 1'b1;
                ovf_set <= acc[FULL_W-1] && (cnt == '0);
              end else begin
                acc <= acc << 1;
                cnt <= cnt + 1'b1;
              end
            end else begin
              acc   <= dir ? (acc >> 1) : (acc << 1);
              stepc <= stepc - 1'b1;
              if (last) begin busy <= 1'b0; fin <= 1'b1; end
            end
          end
        endcase
      end else if (wr) begin
        case (waddr)
          A_OP0: acc[7:0]   <= wdata;
          A_OP1: acc[15:8]  <= wdata;
          A_OP2: acc[23:16] <= wdata;
          A_OP3: acc[31:24] <= wdata;
          A_OP4: hi[7:0]    <= wdata;
          A_OP5: hi[15:8]   <= wdata;
          A_CTRL: begin dir <= wdata[BYTE_W-1]; cnt <= wdata[CNT_W-1:0]; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (raddr)
      A_OP0:   rbyte = acc[7:0];
      A_OP1:   rbyte = acc[15:8];
      A_OP2:   rbyte = acc[23:16];
      A_OP3:   rbyte = acc[31:24];
      A_OP4:   rbyte = hi[7:0];
      A_OP5:   rbyte = hi[15:8];
      A_CTRL:  rbyte = {dir, {(BYTE_W-1-CNT_W){1'b0}}, cnt};
      default: rbyte = '0;
    endcase
  end

  // R2: the partial remainder stays below the divisor throughout a divide
  p_rem_below_divisor_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && (run_op == OP_DIV32 || run_op == OP_DIV16)) |-> (hi < dvs));
  // R6: a normalize that stopped before saturating left bit 31 set
  p_norm_msb_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && run_op == OP_SHIFT && norm && cnt != '1) |-> acc[FULL_W-1]);
endmodule

// File: rtl/muldiv_copro.sv
module muldiv_copro
  import mdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       busy
);
  logic    seq_wr, start, fin, ovf_set, op_acc;
  logic    done, ovf, err;
  mdu_op_e op;
  logic [BYTE_W-1:0] rbyte;

  assign seq_wr = wr_en && !busy;
  assign op_acc = (addr <= A_OP5);

  mdu_seq u_seq (
    .clk(clk), .rst(rst), .wr(seq_wr), .addr(addr), .start(start), .op(op)
  );

  mdu_core u_core (
    .clk(clk), .rst(rst), .start(start), .op(op), .wr(seq_wr), .waddr(addr),
    .wdata(wdata), .raddr(addr), .rbyte(rbyte), .busy(busy), .fin(fin),
    .ovf_set(ovf_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0; ovf <= 1'b0; err <= 1'b0; rdata <= '0;
    end else begin
      if (start)    done <= 1'b0;
      else if (fin) done <= 1'b1;

      if (seq_wr && addr == A_OP0) ovf <= 1'b0;
      else if (ovf_set)            ovf <= 1'b1;

      if (busy && (wr_en || rd_en) && op_acc)       err <= 1'b1;
      else if (!busy && done && rd_en && op_acc)    err <= 1'b0;

      if (rd_en) rdata <= (addr == A_STAT) ? {5'b0, err, ovf, done} : rbyte;
    end
  end

  // R8: a launch clears done
  p_done_clr_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);
  // R8: done and busy are never high together
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: operand access while busy latches the error flag
  p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && (wr_en || rd_en) && op_acc) |=> err);
  // R7: an accepted OP0 write clears overflow
  p_ovf_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && addr == A_OP0) |=> !ovf);
endmodule

// File: tb/muldiv_copro_tb.sv
`timescale 1ns/1ps
module muldiv_copro_tb_top;
  logic clk = 1'b0;
  logic rst, wr_en, rd_en;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic busy;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  muldiv_copro dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic get_res(output logic [31:0] q, output logic [15:0] r, output logic [7:0] st);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(3'(i), b); q[i*8 +: 8] = b; end
    rd(3'd4, b); r[7:0] = b;
    rd(3'd5, b); r[15:8] = b;
    rd(3'd7, st);
  endtask

  task automatic load32(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(3'(i), v[i*8 +: 8]);
  endtask

  function automatic logic [5:0] clz_cap(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 6'(31 - i);
    return 6'd31;
  endfunction

  task automatic do_div32(input logic [31:0] a, input logic [15:0] b);
    int n; logic [31:0] q; logic [15:0] r; logic [7:0] st;
    load32(a); wr(3'd4, b[7:0]); wr(3'd5, b[15:8]);
    wait_busy(n); get_res(q, r, st);
    if (b == 0) begin
      chk("R7 div0 cycles", n, 0);
      chk("R7 div0 operands", q, a);
      chk("R7 div0 overflow", st[1], 1);
    end else begin
      chk("R2 cycles", n, 32);
      chk("R2 quotient", q, a / b);
      chk("R2 remainder", r, a % b);
      chk("R7 no overflow", st[1], 0);
    end
    chk("R8 done", st[0], 1);
  endtask

  task automatic do_div16(input logic [15:0] a, input logic [15:0] b);
    int n; logic [31:0] q; logic [15:0] r; logic [7:0] st;
    wr(3'd0, a[7:0]); wr(3'd1, a[15:8]); wr(3'd4, b[7:0]); wr(3'd5, b[15:8]);
    wait_busy(n); get_res(q, r, st);
    chk("R3 cycles", n, 16);
    chk("R3 quotient", q, {16'b0, a / b});
    chk("R3 remainder", r, a % b);
    chk("R8 done", st[0], 1);
  endtask

  task automatic do_mul(input logic [15:0] a, input logic [15:0] b);
    int n; logic [31:0] q, p; logic [15:0] r; logic [7:0] st;
    p = a * b;
    wr(3'd0, a[7:0]); wr(3'd4, b[7:0]); wr(3'd1, a[15:8]); wr(3'd5, b[15:8]);
    wait_busy(n); get_res(q, r, st);
    chk("R4 cycles", n, 16);
    chk("R4 product", q, p);
    chk("R7 mul overflow", st[1], (p > 32'h0000FFFF) ? 1 : 0);
  endtask

  task automatic do_shift(input logic [31:0] v, input logic dir, input logic [4:0] c);
    int n; logic [31:0] q, e; logic [15:0] r; logic [7:0] st, cb;
    load32(v); wr(3'd6, {dir, 2'b0, c});
    wait_busy(n); get_res(q, r, st); rd(3'd6, cb);
    if (c != 0) begin
      e = dir ? (v >> c) : (v << c);
      chk("R5 cycles", n, c);
      chk("R5 shifted value", q, e);
      chk("R7 shift overflow", st[1], 0);
    end else begin
      e = v << clz_cap(v);
      chk("R6 normalized value", q, e);
      chk("R6 shift count", cb[4:0], clz_cap(v));
      chk("R7 normalize overflow", st[1], v[31] ? 1 : 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [31:0] q;
    logic [15:0] r;
    int n;
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 reset rdata", rdata, 0);
    rd(3'd7, b); chk("R10 reset status", b, 0);

    // R1: sequences not opened by OP0, or broken, never launch
    wr(3'd1, 8'h10); wr(3'd4, 8'h02); wr(3'd5, 8'h00);
    chk("R1 no start without OP0", busy, 0);
    wr(3'd0, 8'h10); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd6, 8'h03);
    chk("R1 broken order", busy, 0);
    rd(3'd7, b); chk("R1 done stays low", b[0], 0);
    rd(3'd0, b); chk("R10 readback", b, 8'h10);

    // directed corners
    do_div32(32'hFFFFFFFF, 16'h0001);
    do_div32(32'h12345678, 16'hFFFF);
    do_div32(32'h00ABCDEF, 16'h0000);
    rd(3'd0, b); wr(3'd0, 8'h00); rd(3'd7, b);
    chk("R7 overflow cleared by OP0", b[1], 0);
    do_mul(16'hFFFF, 16'hFFFF);
    do_mul(16'h00FF, 16'h0101);
    do_shift(32'h80000000, 1'b0, 5'd0);
    do_shift(32'h00000000, 1'b1, 5'd0);
    do_shift(32'h00000001, 1'b0, 5'd31);
    do_shift(32'h80000000, 1'b1, 5'd31);

    // R9: operand access during a calculation
    load32(32'h0F0F0F0F); wr(3'd4, 8'h07); wr(3'd5, 8'h00);
    wr(3'd0, 8'hAA); rd(3'd1, b);
    wait_busy(n);
    rd(3'd7, b);
    chk("R9 error set", b[2], 1);
    chk("R8 done after run", b[0], 1);
    get_res(q, r, b);
    chk("R9 write ignored", q, 32'h0F0F0F0F / 7);
    chk("R9 error cleared by read", b[2], 0);

    // constrained random trials
    for (int i = 0; i < 12; i++) begin
      do_div32($urandom, 16'($urandom | 1) >> ($urandom % 16));
      do_div16(16'($urandom), 16'($urandom | 1) >> ($urandom % 16));
      do_mul(16'($urandom) >> ($urandom % 16), 16'($urandom) >> ($urandom % 16));
      do_shift($urandom, 1'($urandom), 5'($urandom % 31 + 1));
      do_shift($urandom >> ($urandom % 33), 1'($urandom), 5'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule